// File: doc/BRIEF.md
# Keypress Falling-Edge Wake Detector

This block watches an eight-line keyboard return port and records a falling edge on any line whose detection has been switched on. Each recorded edge sets a sticky per-line flag. While an unmasked flag is pending and the global key interrupt is allowed, a level interrupt asks firmware to scan the key matrix. The processor therefore only scans after a key closes, and does not poll.

Three byte-wide registers sit on a simple register bus with a combinational read path and clocked writes. The port latch sets the direction of each line: a 1 leaves the line as a pulled-up input, and a 0 pulls it low. The detect-enable register picks the lines whose edges are recorded. The flag register holds the recorded edges, and a write can only clear its bits. The pins arrive already debounced. Each pin passes through a two-stage synchronizer and then a two-state line tracker (`LINE_HIGH`, `LINE_LOW`). The tracker takes the `fall` transition (`LINE_HIGH` to `LINE_LOW`), which raises a one-clock edge pulse, or the `rise` transition (`LINE_LOW` to `LINE_HIGH`), which raises nothing. Any other cycle is a `hold` in the current state.

Top module: `kd_wake_detect`

## Requirements
- R1: Right after reset, the flag register reads 00h, the port latch reads FFh, `key_drive_low` is 00h and `key_irq` is 0.
- R2: A high-to-low change of line n (bit n of every register maps to line n) with enable bit n at 1 sets flag bit n and no other flag bit.
- R3: With enable bit n at 0, a falling edge on line n leaves flag bit n at 0.
- R4: A low-to-high change on a line never sets its flag.
- R5: Writing the flag register (address A6h) clears every bit that is written as 0 and leaves every bit that is written as 1 unchanged. Writing 00h clears all flags.
- R6: If a new falling edge and a write of 0 reach the same flag bit in the same clock, the flag bit ends up at 1.
- R7: `key_irq` is 1 exactly when `key_irq_en` is 1 and at least one flag bit is 1 whose enable bit is also 1.
- R8: Port latch bit n at 0 sets `key_drive_low[n]`, and the line is then treated as low by the detector. A line with enable bit n at 1 that is pulled low this way therefore sets flag bit n.
- R9: Reads are combinational: address A5h returns the enable register, A6h the flag register, 90h the port latch, and any other address 00h.
- R10: A set flag stays set after its line returns high and after its enable bit or `key_irq_en` is cleared, until a write clears it.
- R11: Flag bit n is still 0 two clock edges after the pin falls and is 1 after the third edge. Two edges go to the synchronizer and one to the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_we | input | 1 | Write strobe, acted on at the clock edge |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Combinational read data |
| key_pin_in | input | 8 | Debounced return-line levels (1 = idle, pulled up) |
| key_drive_low | output | 8 | Per-line pull-down request (1 = drive the line low) |
| key_irq_en | input | 1 | Global key-detect interrupt enable |
| key_irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is the race in R6: a fresh falling edge must reach the flag register in the same clock as a clearing write. The bench first sets the flag, returns the line high and lets it settle. It then drops the pin at a known falling clock edge and counts two rising edges through the synchronizer. It places the clearing write so that the write strobe is sampled on the third edge, which is the same edge that captures the detected edge. Checks one edge early and one edge late (R11) confirm that this alignment is correct.

// File: rtl/kd_pkg.sv
package kd_pkg;

    localparam int KD_LINES = 8;
    localparam int KD_ADDR_W = 8;
    localparam int KD_SYNC_STAGES = 2;

    localparam logic [KD_ADDR_W-1:0] KD_ADDR_PORT = 8'h90;
    localparam logic [KD_ADDR_W-1:0] KD_ADDR_ENABLE = 8'hA5;
    localparam logic [KD_ADDR_W-1:0] KD_ADDR_FLAG = 8'hA6;

    typedef enum logic [0:0] {
        LINE_HIGH = 1'b0,
        LINE_LOW  = 1'b1
    } line_state_e;

endpackage

// File: rtl/kd_sync.sv
module kd_sync #(
    parameter int WIDTH = 8,
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            chain_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign d_out = chain_q[LAST];

endmodule

// File: rtl/kd_line_fsm.sv
module kd_line_fsm
    import kd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall_pulse
);

    line_state_e state_q;
    line_state_e state_d;

    // Next-state selection: fall, rise or hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_HIGH: if (!level) state_d = LINE_LOW;
            LINE_LOW:  if (level)  state_d = LINE_HIGH;
            default:   state_d = LINE_HIGH;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: only the fall transition produces a pulse.
    always_comb begin
        fall_pulse = 1'b0;
        unique case (state_q)
            LINE_HIGH: fall_pulse = !level;
            LINE_LOW:  fall_pulse = 1'b0;
            default:   fall_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/kd_regs.sv
module kd_regs
    import kd_pkg::*;
#(
    parameter int LINES = KD_LINES,
    parameter int ADDR_W = KD_ADDR_W,
    parameter logic [ADDR_W-1:0] ADDR_PORT = KD_ADDR_PORT,
    parameter logic [ADDR_W-1:0] ADDR_ENABLE = KD_ADDR_ENABLE,
    parameter logic [ADDR_W-1:0] ADDR_FLAG = KD_ADDR_FLAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  fall_in,
    output logic [LINES-1:0]  latch_q,
    output logic [LINES-1:0]  enable_q,
    output logic [LINES-1:0]  flag_q,
    output logic [LINES-1:0]  rdata
);

    logic wr_port;
    logic wr_enable;
    logic wr_flag;
    logic [LINES-1:0] clear_mask;
    logic [LINES-1:0] set_mask;
    logic [LINES-1:0] flag_d;

    assign wr_port   = we && (addr == ADDR_PORT);
    assign wr_enable = we && (addr == ADDR_ENABLE);
    assign wr_flag   = we && (addr == ADDR_FLAG);

    assign clear_mask = wr_flag ? ~wdata : '0;
    assign set_mask   = fall_in & enable_q;
    // A new edge overrides a clear in the same cycle.
    assign flag_d     = (flag_q & ~clear_mask) | set_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else if (wr_port) begin
            latch_q <= wdata;
        end
    end

    // No reset: software programs the enables before relying on them.
    always_ff @(posedge clk) begin
        if (wr_enable) begin
            enable_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_PORT:   rdata = latch_q;
            ADDR_ENABLE: rdata = enable_q;
            ADDR_FLAG:   rdata = flag_q;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/kd_wake_detect.sv
module kd_wake_detect
    import kd_pkg::*;
#(
    parameter int LINES = KD_LINES,
    parameter int ADDR_W = KD_ADDR_W,
    parameter int SYNC_STAGES = KD_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_we,
    input  logic [LINES-1:0]  sfr_wdata,
    output logic [LINES-1:0]  sfr_rdata,
    input  logic [LINES-1:0]  key_pin_in,
    output logic [LINES-1:0]  key_drive_low,
    input  logic              key_irq_en,
    output logic              key_irq
);

    logic [LINES-1:0] latch_q;
    logic [LINES-1:0] enable_q;
    logic [LINES-1:0] flag_q;
    logic [LINES-1:0] line_level;
    logic [LINES-1:0] line_sync;
    logic [LINES-1:0] edge_pulse;

    // A latch bit of 0 pulls its line low, so the detector sees it low.
    assign line_level    = key_pin_in & latch_q;
    assign key_drive_low = ~latch_q;

    kd_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (line_level),
        .d_out(line_sync)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        kd_line_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (line_sync[n]),
            .fall_pulse(edge_pulse[n])
        );
    end

    kd_regs #(
        .LINES (LINES),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (sfr_addr),
        .we      (sfr_we),
        .wdata   (sfr_wdata),
        .fall_in (edge_pulse),
        .latch_q (latch_q),
        .enable_q(enable_q),
        .flag_q  (flag_q),
        .rdata   (sfr_rdata)
    );

    assign key_irq = key_irq_en && |(flag_q & enable_q);

endmodule

// File: rtl/kd_wake_detect_chk.sv
module kd_wake_detect_chk
    import kd_pkg::*;
#(
    parameter int LINES = KD_LINES,
    parameter int ADDR_W = KD_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_we,
    input logic [LINES-1:0]  sfr_wdata,
    input logic [LINES-1:0]  flag_q,
    input logic [LINES-1:0]  enable_q,
    input logic [LINES-1:0]  edge_pulse,
    input logic              key_irq_en,
    input logic              key_irq
);

    // R1
    flags_clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_q == '0));

    // R2
    flag_rises_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(edge_pulse)) == '0));

    // R3
    flag_rises_only_if_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(enable_q)) == '0));

    // R6
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(edge_pulse & enable_q) & ~flag_q) == '0));

    // R10
    flag_falls_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_q) & ~flag_q &
          ~(($past(sfr_we) && ($past(sfr_addr) == KD_ADDR_FLAG)) ? ~$past(sfr_wdata) : '0)) == '0));

    // R7
    irq_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |-> key_irq_en);

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |-> !key_irq);

endmodule

bind kd_wake_detect kd_wake_detect_chk #(
    .LINES (LINES),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .flag_q    (flag_q),
    .enable_q  (enable_q),
    .edge_pulse(edge_pulse),
    .key_irq_en(key_irq_en),
    .key_irq   (key_irq)
);

// File: tb/kd_wake_detect_test.sv
module kd_wake_detect_test;

    localparam logic [7:0] A_PORT = 8'h90;
    localparam logic [7:0] A_EN   = 8'hA5;
    localparam logic [7:0] A_FLAG = 8'hA6;

    // {pins, expected flags}, enables FFh, flags start at 00h.
    localparam int NVEC = 7;
    localparam logic [15:0] VEC [NVEC] = '{
        16'hFF_00, 16'hFE_01, 16'hFF_01, 16'h7E_81,
        16'h7F_81, 16'h00_FF, 16'hFF_FF
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic [7:0] key_pin_in = 8'hFF;
    logic [7:0] key_drive_low;
    logic       key_irq_en = 1'b0;
    logic       key_irq;

    int total = 0;
    int bad = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    kd_wake_detect uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sfr_addr     (sfr_addr),
        .sfr_we       (sfr_we),
        .sfr_wdata    (sfr_wdata),
        .sfr_rdata    (sfr_rdata),
        .key_pin_in   (key_pin_in),
        .key_drive_low(key_drive_low),
        .key_irq_en   (key_irq_en),
        .key_irq      (key_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a;
        sfr_wdata = d;
        sfr_we = 1'b1;
        tick(1);
        sfr_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(A_FLAG, rv); check("R1 flags", rv, 8'h00);
        rd(A_PORT, rv); check("R1 latch", rv, 8'hFF);
        check("R1 drive", key_drive_low, 8'h00);
        check("R1 irq", {7'd0, key_irq}, 8'h00);
        // R9 unmapped address
        rd(8'h33, rv); check("R9 other", rv, 8'h00);

        wr(A_EN, 8'hFF);
        key_irq_en = 1'b1;
        rd(A_EN, rv); check("R9 enable", rv, 8'hFF);

        // R2 R4 R10 vector walk
        for (int i = 0; i < NVEC; i++) begin
            key_pin_in = VEC[i][15:8];
            tick(4);
            rd(A_FLAG, rv);
            check($sformatf("R2 R4 R10 vec%0d", i), rv, VEC[i][7:0]);
            check($sformatf("R7 vec%0d", i), {7'd0, key_irq}, {7'd0, VEC[i][7:0] != 0});
        end

        // R5 partial clear, then full clear
        wr(A_FLAG, 8'h0F);
        rd(A_FLAG, rv); check("R5 partial", rv, 8'h0F);
        check("R7 still pending", {7'd0, key_irq}, 8'h01);
        wr(A_FLAG, 8'h00);
        rd(A_FLAG, rv); check("R5 full", rv, 8'h00);
        check("R7 cleared", {7'd0, key_irq}, 8'h00);

        // R3 disabled lines
        wr(A_EN, 8'h00);
        key_pin_in = 8'h00;
        tick(4);
        rd(A_FLAG, rv); check("R3 disabled", rv, 8'h00);
        key_pin_in = 8'hFF;
        tick(4);

        // R7 masking and R10 persistence
        wr(A_EN, 8'h01);
        key_pin_in = 8'hFE;
        tick(4);
        check("R7 raised", {7'd0, key_irq}, 8'h01);
        key_irq_en = 1'b0;
        tick(1);
        check("R7 global off", {7'd0, key_irq}, 8'h00);
        key_irq_en = 1'b1;
        wr(A_EN, 8'h00);
        check("R7 line masked", {7'd0, key_irq}, 8'h00);
        rd(A_FLAG, rv); check("R10 kept", rv, 8'h01);
        wr(A_FLAG, 8'h00);
        key_pin_in = 8'hFF;
        wr(A_EN, 8'hFF);
        tick(4);

        // R11 latency
        key_pin_in = 8'hFE;
        tick(2);
        rd(A_FLAG, rv); check("R11 early", rv, 8'h00);
        tick(1);
        rd(A_FLAG, rv); check("R11 on time", rv, 8'h01);
        wr(A_FLAG, 8'h00);
        key_pin_in = 8'hFF;
        tick(4);

        // R6 edge and clear in the same clock
        key_pin_in = 8'hFD;
        tick(4);
        key_pin_in = 8'hFF;
        tick(4);
        rd(A_FLAG, rv); check("R6 setup", rv, 8'h02);
        key_pin_in = 8'hFD;
        tick(2);
        wr(A_FLAG, 8'h00);
        rd(A_FLAG, rv); check("R6 race", rv, 8'h02);
        wr(A_FLAG, 8'h00);
        key_pin_in = 8'hFF;
        tick(4);

        // R8 latch pulls a line low
        wr(A_PORT, 8'hFE);
        check("R8 drive", key_drive_low, 8'h01);
        rd(A_PORT, rv); check("R9 port", rv, 8'hFE);
        tick(4);
        rd(A_FLAG, rv); check("R8 flag", rv, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule